// File: doc/BRIEF.md
# Serial Byte and Block Sync Acquisition

This block recovers byte and block framing from a receiver bit stream that is delivered two bits at a time. Each clock whose valid strobe is high carries one new bit pair. Cycles with the strobe low carry nothing. The stream has no byte alignment of its own. The block therefore hunts for the block sync pattern at every bit offset. Once it has found the pattern, it fixes the bit phase and delivers whole bytes on a byte strobe. A start flag marks the sync byte that opens each 204-byte block.

A confidence ladder with seven levels (0 to 6) judges the lock. A sync byte counts if it is either the plain pattern 47h or its bitwise inverse B8h. Each sync byte that lands exactly one block after the previous one raises the level by one. A miss below the top level sends the block back to hunting. At the top level a single miss only steps the level down by one, so one corrupted sync byte does not cost the lock. The not-synchronized output is low only while the ladder sits at its top level. Downstream stages such as the de-interleaver, the error decoder and the descrambler rely on the start flag and on this status.

Top module: `rsync_acquire`

## Requirements
- R1: On each clock with `din_vld` high, `din_hi` carries the earlier bit of the pair and `din_lo` the later one. Bytes are assembled most significant bit first, so the first bit of a byte appears on `byte_out[7]`.
- R2: Clocks with `din_vld` low leave the framing untouched, whatever values are on the data inputs. Any pattern of valid and idle clocks is accepted, and no byte strobe follows an idle clock.
- R3: While hunting, the block tests every bit offset for 47h or B8h. The first match becomes the block's first byte, delivered with `byte_stb` and `blk_start` both high, and the ladder moves to level 1.
- R4: Once framed, the block delivers every byte in stream order. `blk_start` is high on every 204th byte (block position 0) and low on the other 203 bytes. While locked, a flagged byte is always 47h or B8h.
- R5: `no_sync` falls on the same clock as the `blk_start` of the sixth consecutive correctly placed sync byte. It stays high before that clock.
- R6: Below the top level, a byte at block position 0 that is neither 47h nor B8h sends the block back to hunting. That byte is not delivered.
- R7: At the top level, a single missing sync byte lowers the level to 5. The byte is still delivered with `blk_start`, and `no_sync` rises on that same clock. The next correct sync byte restores the top level and drops `no_sync` again.
- R8: Two consecutive missing sync bytes that start from the top level lose the lock. The block then hunts again, and `no_sync` stays high.
- R9: A synchronous active-high `rst` forces hunting, `no_sync` = 1, `byte_stb` = 0 and `blk_start` = 0 on the clock after it is sampled.
- R10: A byte is presented on the clock edge that consumes its last bit. The outputs are registered, so `byte_stb` is high in the cycle that follows the valid clock carrying that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_hi | input | 1 | Earlier (more significant) bit of the pair |
| din_lo | input | 1 | Later (less significant) bit of the pair |
| din_vld | input | 1 | High when the bit pair is valid |
| byte_out | output | 8 | Aligned output byte |
| byte_stb | output | 1 | High for one cycle per delivered byte |
| blk_start | output | 1 | High with the first byte of a block |
| no_sync | output | 1 | High unless fully locked |

## Verification
Streams of 204-byte blocks are sent after leading filler of even and odd bit counts, so the sync pattern appears at both pair phases. Some streams run with no idle clocks and others with idle clocks inserted every few cycles, carrying random data while idle. This shows whether the search and the phase counter ignore idle cycles. Corrupted sync bytes are placed before lock, at full lock, and twice in a row at full lock, which separates the drop-to-hunt path from the single-step fallback. A five-block stream and a six-block stream check the exact lock threshold. Short directed bursts fix the cycle in which a byte appears for an aligned 47h and for an unaligned B8h.

// File: rtl/rsync_pkg.sv
`timescale 1ns/1ps
package rsync_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SYNC_PLAIN = 8'h47;
    localparam byte_t SYNC_FLIP  = 8'hB8;

    // True for either polarity of the block sync pattern.
    function automatic logic is_sync(input byte_t b);
        return (b == SYNC_PLAIN) || (b == SYNC_FLIP);
    endfunction
endpackage

// File: rtl/rsync_shifter.sv
`timescale 1ns/1ps
// Keeps the last BYTE_W-1 valid bits and forms the two candidate byte
// windows that end on the earlier and on the later bit of the current pair.
module rsync_shifter
    import rsync_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_hi,
    input  logic  bit_lo,
    input  logic  vld,
    output byte_t win_early,
    output byte_t win_late
);
    localparam int HIST_W = BYTE_W - 1;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } shf_t;

    shf_t              s_d, s_q;
    logic [BYTE_W:0]   joined;

    always_comb begin
        joined    = {s_q.hist, bit_hi, bit_lo};
        win_early = joined[BYTE_W:1];
        win_late  = joined[BYTE_W-1:0];
        s_d       = s_q;
        if (vld) begin
            s_d.hist = joined[HIST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rsync_framer.sv
`timescale 1ns/1ps
// Hunts for the sync pattern at both bit phases of a pair, then tracks the
// pair count inside a byte and the byte position inside a block.
module rsync_framer
    import rsync_pkg::*;
#(
    parameter int BLK_LEN = 204
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hunt,
    input  logic  vld,
    input  byte_t win_early,
    input  byte_t win_late,
    output logic  found,
    output byte_t found_byte,
    output logic  byte_done,
    output byte_t byte_val,
    output logic  at_head
);
    localparam int PAIRS = BYTE_W / 2;
    localparam int PC_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int POS_W = $clog2(BLK_LEN);
    localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PAIRS - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_LEN - 1);
    localparam logic [POS_W-1:0] POS_NEXT = POS_W'(1);

    typedef struct packed {
        logic             early;   // byte ends on the earlier bit of a pair
        logic [PC_W-1:0]  pc;      // pairs taken since the byte boundary
        logic [POS_W-1:0] pos;     // block position of the byte in progress
    } frm_t;

    frm_t f_d, f_q;
    logic hit_e, hit_l;

    always_comb begin
        f_d        = f_q;
        hit_e      = is_sync(win_early);
        hit_l      = is_sync(win_late);
        found      = 1'b0;
        found_byte = hit_e ? win_early : win_late;
        byte_done  = 1'b0;
        byte_val   = f_q.early ? win_early : win_late;
        at_head    = (f_q.pos == '0);

        if (vld) begin
            if (hunt) begin
                if (hit_e || hit_l) begin
                    found     = 1'b1;
                    f_d.early = hit_e;
                    f_d.pc    = '0;
                    f_d.pos   = POS_NEXT;
                end
            end else begin
                f_d.pc = (f_q.pc == PC_LAST) ? '0 : f_q.pc + 1'b1;
                if (f_q.pc == PC_LAST) begin
                    byte_done = 1'b1;
                    f_d.pos   = (f_q.pos == POS_LAST) ? '0 : f_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end
endmodule

// File: rtl/rsync_ladder.sv
`timescale 1ns/1ps
// Lock confidence ladder: 0 is hunting, LEVEL_MAX is full lock.
module rsync_ladder #(
    parameter int LEVEL_MAX = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic found,
    input  logic head_seen,
    input  logic head_ok,
    output logic hunting,
    output logic full
);
    localparam int LV_W = $clog2(LEVEL_MAX + 1);
    localparam logic [LV_W-1:0] LV_TOP  = LV_W'(LEVEL_MAX);
    localparam logic [LV_W-1:0] LV_BACK = LV_W'(LEVEL_MAX - 1);
    localparam logic [LV_W-1:0] LV_ONE  = LV_W'(1);

    typedef struct packed {
        logic [LV_W-1:0] level;
    } lad_t;

    lad_t l_d, l_q;

    always_comb begin
        l_d     = l_q;
        hunting = (l_q.level == '0);
        full    = (l_q.level == LV_TOP);
        if (hunting) begin
            if (found) begin
                l_d.level = LV_ONE;
            end
        end else if (head_seen) begin
            if (head_ok) begin
                l_d.level = full ? LV_TOP : l_q.level + 1'b1;
            end else begin
                l_d.level = full ? LV_BACK : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end
endmodule

// File: rtl/rsync_acquire.sv
`timescale 1ns/1ps
module rsync_acquire
    import rsync_pkg::*;
#(
    parameter int BLK_LEN   = 204,
    parameter int LEVEL_MAX = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        din_hi,
    input  logic        din_lo,
    input  logic        din_vld,
    output logic [7:0]  byte_out,
    output logic        byte_stb,
    output logic        blk_start,
    output logic        no_sync
);
    typedef struct packed {
        byte_t data;
        logic  stb;
        logic  start;
    } out_t;

    out_t  o_d, o_q;
    byte_t win_early, win_late, found_byte, byte_val;
    logic  found, byte_done, at_head;
    logic  hunting, full, head_seen, head_ok, head_drop, emit;

    rsync_shifter i_shifter (
        .clk       (clk),
        .rst       (rst),
        .bit_hi    (din_hi),
        .bit_lo    (din_lo),
        .vld       (din_vld),
        .win_early (win_early),
        .win_late  (win_late)
    );

    rsync_framer #(.BLK_LEN(BLK_LEN)) i_framer (
        .clk        (clk),
        .rst        (rst),
        .hunt       (hunting),
        .vld        (din_vld),
        .win_early  (win_early),
        .win_late   (win_late),
        .found      (found),
        .found_byte (found_byte),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .at_head    (at_head)
    );

    rsync_ladder #(.LEVEL_MAX(LEVEL_MAX)) i_ladder (
        .clk       (clk),
        .rst       (rst),
        .found     (found),
        .head_seen (head_seen),
        .head_ok   (head_ok),
        .hunting   (hunting),
        .full      (full)
    );

    always_comb begin
        head_seen = byte_done && at_head;
        head_ok   = is_sync(byte_val);
        // A missed head below full lock restarts the hunt: the byte is dropped.
        head_drop = head_seen && !head_ok && !full;
        emit      = found || (byte_done && !head_drop);
        o_d.data  = found ? found_byte : byte_val;
        o_d.stb   = emit;
        o_d.start = emit && (found || at_head);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign byte_out  = o_q.data;
    assign byte_stb  = o_q.stb;
    assign blk_start = o_q.start;
    assign no_sync   = !full;
endmodule

// File: rtl/rsync_acquire_chk.sv
`timescale 1ns/1ps
module rsync_acquire_chk (
    input logic       clk,
    input logic       rst,
    input logic       din_vld,
    input logic [7:0] byte_out,
    input logic       byte_stb,
    input logic       blk_start,
    input logic       no_sync
);
    logic rst_q = 1'b0;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_state_R9: assert (no_sync && !byte_stb && !blk_start)
                else $error("reset state violated");
        end
    end

    assert_idle_no_byte_R2: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> !byte_stb);

    assert_start_has_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> byte_stb);

    assert_locked_head_sync_R4: assert property (@(posedge clk) disable iff (rst)
        (blk_start && !no_sync) |-> (byte_out == 8'h47 || byte_out == 8'hB8));

    assert_lock_on_head_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(no_sync) |-> blk_start);

    assert_unlock_on_head_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(no_sync) && !$past(rst)) |-> blk_start);
endmodule

bind rsync_acquire rsync_acquire_chk i_rsync_acquire_chk (
    .clk       (clk),
    .rst       (rst),
    .din_vld   (din_vld),
    .byte_out  (byte_out),
    .byte_stb  (byte_stb),
    .blk_start (blk_start),
    .no_sync   (no_sync)
);

// File: tb/test_rsync_acquire.sv
`timescale 1ns/1ps
module test_rsync_acquire;
    localparam int BLK = 204;
    localparam int WATCHDOG = 190000;

    typedef struct packed {
        int lead;      // filler bits before the first sync
        int gap;       // idle clock every gap clocks (0 = none)
        int nblk;      // blocks sent
        int mask;      // blocks whose sync byte is corrupted to 00h
        int bytes;     // expected delivered bytes
        int starts;    // expected start flags
        int heads;     // expected flagged bytes that are not sync
        int nsync_end; // expected no_sync after the stream
        int lock_at;   // start count at which no_sync first falls (0 = never)
    } scen_t;

    localparam scen_t SCN [8] = '{
        '{0,  0, 8, 0,   1632, 8, 0, 0, 6},
        '{3,  3, 8, 0,   1632, 8, 0, 0, 6},
        '{13, 5, 8, 0,   1632, 8, 0, 0, 6},
        '{1,  0, 9, 4,   1632, 8, 0, 0, 8},
        '{6,  4, 9, 64,  1836, 9, 1, 0, 6},
        '{2,  0, 9, 192, 1632, 8, 1, 1, 6},
        '{5,  2, 6, 0,   1224, 6, 0, 0, 6},
        '{4,  0, 5, 0,   1020, 5, 0, 1, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din_hi = 1'b0, din_lo = 1'b0, din_vld = 1'b0;
    logic [7:0] byte_out;
    logic byte_stb, blk_start, no_sync;

    int checks = 0, errors = 0, cyc = 0;
    bit mon_on = 0;
    int n_bytes, n_starts, n_heads, pay_err, lock_at, pos;
    bit locked_seen;

    always #5 clk = ~clk;

    rsync_acquire i_rsync_acquire (
        .clk(clk), .rst(rst), .din_hi(din_hi), .din_lo(din_lo), .din_vld(din_vld),
        .byte_out(byte_out), .byte_stb(byte_stb), .blk_start(blk_start), .no_sync(no_sync)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stream monitor: payload byte at block position p is {4'h0, p[3:0]}.
    always @(negedge clk) begin
        if (mon_on && byte_stb) begin
            n_bytes++;
            if (blk_start) begin
                n_starts++;
                pos = 0;
                if (!(byte_out == 8'h47 || byte_out == 8'hB8)) n_heads++;
            end else begin
                pos++;
                if (pos > BLK - 1 || byte_out != {4'h0, 4'(pos)}) pay_err++;
            end
        end
        if (mon_on && !no_sync && !locked_seen) begin
            locked_seen = 1;
            lock_at = n_starts;
        end
    end

    function automatic logic sbit(input scen_t s, input int idx);
        int j, b, blk, p;
        logic [7:0] v;
        if (idx < s.lead || idx >= s.lead + s.nblk * BLK * 8) return 1'b0;
        j   = idx - s.lead;
        b   = j / 8;
        blk = b / BLK;
        p   = b % BLK;
        if (p == 0) begin
            if (((s.mask >> blk) & 1) != 0) v = 8'h00;
            else v = (blk % 8 == 0) ? 8'hB8 : 8'h47;
        end else begin
            v = {4'h0, 4'(p)};
        end
        return v[7 - (j % 8)];
    endfunction

    task automatic put_pair(input logic h, input logic l, input logic v);
        @(negedge clk);
        din_hi = h; din_lo = l; din_vld = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; din_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int k = 7; k > 0; k -= 2) put_pair(b[k], b[k-1], 1'b1);
    endtask

    task automatic run_scn(input scen_t s);
        int idx, c, total;
        do_reset();
        n_bytes = 0; n_starts = 0; n_heads = 0; pay_err = 0; lock_at = 0; pos = 0;
        locked_seen = 0;
        mon_on = 1;
        total = s.lead + s.nblk * BLK * 8;
        idx = 0; c = 0;
        while (idx < total) begin
            if (s.gap > 0 && (c % s.gap) == s.gap - 1)
                put_pair(1'($urandom), 1'($urandom), 1'b0);
            else begin
                put_pair(sbit(s, idx), sbit(s, idx + 1), 1'b1);
                idx += 2;
            end
            c++;
        end
        repeat (3) put_pair(1'b0, 1'b0, 1'b0);
        mon_on = 0;
    endtask

    initial begin
        // R9: state straight after reset
        do_reset();
        @(negedge clk);
        check(no_sync && !byte_stb && !blk_start, "R9 reset state", {no_sync, byte_stb, blk_start}, 3'b100);

        for (int i = 0; i < 8; i++) begin
            run_scn(SCN[i]);
            check(n_bytes == SCN[i].bytes, $sformatf("R4 R6 scn%0d bytes", i), n_bytes, SCN[i].bytes);
            check(n_starts == SCN[i].starts, $sformatf("R4 R3 scn%0d starts", i), n_starts, SCN[i].starts);
            check(n_heads == SCN[i].heads, $sformatf("R7 scn%0d flagged non-sync", i), n_heads, SCN[i].heads);
            check(no_sync == 1'(SCN[i].nsync_end), $sformatf("R5 R8 scn%0d final no_sync", i), no_sync, SCN[i].nsync_end);
            check(lock_at == SCN[i].lock_at, $sformatf("R5 scn%0d lock point", i), lock_at, SCN[i].lock_at);
            check(pay_err == 0, $sformatf("R1 R2 scn%0d payload order", i), pay_err, 0);
        end

        // R10 / R3: aligned 47h, byte appears after the fourth pair
        do_reset();
        put_pair(1'b0, 1'b1, 1'b1);
        put_pair(1'b0, 1'b0, 1'b1);
        put_pair(1'b0, 1'b1, 1'b1);
        put_pair(1'b1, 1'b1, 1'b1);
        check(!byte_stb, "R10 no byte before last bit", byte_stb, 0);
        put_pair(1'b0, 1'b0, 1'b0);
        check(byte_stb && blk_start, "R10 R3 aligned sync strobe", {byte_stb, blk_start}, 2'b11);
        check(byte_out == 8'h47, "R3 aligned sync value", byte_out, 8'h47);
        check(no_sync, "R5 one sync is not lock", no_sync, 1);

        // R1 / R3: B8h at odd phase, one leading zero bit
        do_reset();
        put_pair(1'b0, 1'b1, 1'b1);
        put_pair(1'b0, 1'b1, 1'b1);
        put_pair(1'b1, 1'b1, 1'b1);
        put_pair(1'b0, 1'b0, 1'b1);
        put_pair(1'b0, 1'b0, 1'b1);
        check(!byte_stb, "R1 odd phase not early", byte_stb, 0);
        put_pair(1'b0, 1'b0, 1'b0);
        check(byte_stb && byte_out == 8'hB8, "R1 R3 odd phase B8", byte_out, 8'hB8);

        // R2: 47h pattern with valid low is ignored
        do_reset();
        begin
            int seen = 0;
            put_pair(1'b0, 1'b1, 1'b0);
            put_pair(1'b0, 1'b0, 1'b0);
            put_pair(1'b0, 1'b1, 1'b0);
            put_pair(1'b1, 1'b1, 1'b0);
            for (int k = 0; k < 6; k++) begin
                put_pair(1'b0, 1'b0, 1'b1);
                if (byte_stb) seen++;
            end
            put_pair(1'b0, 1'b0, 1'b0);
            if (byte_stb) seen++;
            check(seen == 0, "R2 idle sync pattern ignored", seen, 0);
        end

        // R2: idle clocks with sync-like data inside a real sync byte
        do_reset();
        put_pair(1'b0, 1'b1, 1'b1);
        put_pair(1'b1, 1'b1, 1'b0);
        put_pair(1'b0, 1'b0, 1'b1);
        put_pair(1'b1, 1'b0, 1'b0);
        put_pair(1'b0, 1'b1, 1'b1);
        put_pair(1'b1, 1'b1, 1'b1);
        put_pair(1'b0, 1'b0, 1'b0);
        check(byte_stb && byte_out == 8'h47, "R2 gaps inside sync byte", byte_out, 8'h47);

        // R9: reset while fully locked
        run_scn(SCN[0]);
        check(!no_sync, "R5 locked before reset", no_sync, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(no_sync && !byte_stb && !blk_start, "R9 reset from lock", {no_sync, byte_stb, blk_start}, 3'b100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule